// File: doc/BRIEF.md
# NAND Bus Cycle Timing Sequencer

This block turns single register-style requests into correctly timed bus cycles on an 8-bit asynchronous NAND flash device. A request names one of four kinds: command latch, address latch, data write or data read. The block then steps through three phases. A setup phase puts the control and data lines in place. A strobe phase pulses the write or read strobe low. A hold phase keeps the lines steady after the strobe rises.

After the hold phase, the ready/busy line of the device cannot be relied on for a programmable time. The block waits out that time before it accepts the next request. Each phase length comes from a packed 32-bit timing word that holds one set of values for writes and another for reads. Software loads this word once. A configuration bit can hold chip-enable low continuously. A software-reset input puts the sequencer back to idle and clears the configuration and the timing word to zero.

Top module: `nand_strobe_seq`

## Requirements
- R1: The timing word packs the write-side fields in the upper half: ready wait [31:28], strobe width [27:24], hold [23:20], setup [19:16]. It packs the read-side fields in the lower half: ready wait [15:12], strobe width [11:8], hold [7:4], setup [3:0]. A setup, width or hold field value v gives a phase of v+1 clocks. Command, address and data-write accesses use the write fields. Data reads use the read fields.
- R2: req_kind 2'b00 is a command access. nand_cle is high and nand_ale low for every clock of its setup, strobe and hold phases. nand_we_n is low for the strobe phase. nand_dout carries the request byte with nand_dout_en high.
- R3: req_kind 2'b01 is an address access. It behaves like R2, except that nand_ale is high in place of nand_cle.
- R4: req_kind 2'b10 is a data write. nand_cle and nand_ale stay low, nand_we_n pulses low for the strobe phase, and the byte is driven with nand_dout_en high.
- R5: req_kind 2'b11 is a data read. nand_re_n pulses low for the strobe phase and nand_dout_en stays low. nand_din is captured on the last strobe clock. rd_data is then presented with a one-clock rd_valid pulse during the first hold clock.
- R6: After the hold phase, a ready wait of 2*n clocks follows, where n is the ready-wait field of the access's direction. nand_ce_n is high during this wait. A value of 0 gives no wait.
- R7: busy is high from the clock after a request is accepted until the ready wait ends. The total is setup+width+hold+3+2n clocks. A req_valid that arrives while busy is high is dropped and causes no bus cycle.
- R8: dev_ready follows nand_rb with one clock of latency while the block is idle. It holds its value while busy is high, including through the ready wait.
- R9: When the force bit written through cfg_wr is 1, nand_ce_n is low on every clock, idle or busy. When the bit is 0, nand_ce_n is low only during setup, strobe and hold.
- R10: A soft_rst pulse returns the block to idle on the next clock, ends any strobe, and clears the force bit and the timing word to zero. After it, every phase is 1 clock and there is no ready wait.
- R11: nand_we_n and nand_re_n are never low together, and either one is low only while nand_ce_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Software reset: returns to idle and zeroes the configuration |
| tim_wr | input | 1 | Load the timing word |
| tim_wdata | input | 32 | Packed timing word |
| cfg_wr | input | 1 | Load the configuration bit |
| cfg_ce_force | input | 1 | Value for the chip-enable force bit |
| req_valid | input | 1 | Access request, taken when busy is low |
| req_kind | input | 2 | 00 command, 01 address, 10 data write, 11 data read |
| req_data | input | 8 | Byte for command, address or write |
| busy | output | 1 | Access or ready wait in progress |
| rd_data | output | 8 | Byte captured by the last read |
| rd_valid | output | 1 | One-clock pulse with rd_data |
| dev_ready | output | 1 | Sampled ready/busy status |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dout | output | 8 | Byte driven to the device |
| nand_dout_en | output | 1 | Output enable for nand_dout |
| nand_din | input | 8 | Byte from the device |
| nand_rb | input | 1 | Ready/busy pin, 1 = ready |

## Verification
The assertions check the following on every clock:
- the two strobes never overlap, and a strobe is low only inside chip-enable;
- CLE and ALE are never high together;
- the bus is not driven during a read strobe;
- rd_valid is a single pulse that directly follows a read strobe;
- dev_ready stays frozen while busy;
- the force bit holds chip-enable low;
- soft reset leads to idle;
- busy starts only from a request.

The exact length of each phase for each field value, and the choice between write and read fields, can only be shown by the directed scenarios. The same holds for the 2*n ready wait, capture on the last strobe clock rather than an earlier one, and dropped requests while busy.

// File: rtl/nss_pkg.sv
package nss_pkg;
  localparam int FIELD_W = 4;
  localparam int TIM_W   = 8 * FIELD_W;
  localparam int WAIT_W  = FIELD_W + 1;

  typedef enum logic [1:0] {
    K_CMD  = 2'b00,
    K_ADDR = 2'b01,
    K_WR   = 2'b10,
    K_RD   = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_WAIT
  } phase_e;

  typedef struct packed {
    logic [FIELD_W-1:0] rdy;
    logic [FIELD_W-1:0] width;
    logic [FIELD_W-1:0] hold;
    logic [FIELD_W-1:0] setup;
  } dir_tim_t;

  function automatic dir_tim_t pick_dir(input logic [TIM_W-1:0] word, input logic is_read);
    return is_read ? dir_tim_t'(word[TIM_W/2-1:0]) : dir_tim_t'(word[TIM_W-1:TIM_W/2]);
  endfunction

  function automatic logic [WAIT_W-1:0] phase_load(input logic [FIELD_W-1:0] v);
    return {1'b0, v};
  endfunction

  function automatic logic [WAIT_W-1:0] wait_load(input logic [FIELD_W-1:0] n);
    return {n, 1'b0} - WAIT_W'(1);
  endfunction
endpackage

// File: rtl/nss_cfg_regs.sv
module nss_cfg_regs
  import nss_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             tim_wr,
  input  logic [TIM_W-1:0] tim_wdata,
  input  logic             cfg_wr,
  input  logic             cfg_ce_force,
  output logic [TIM_W-1:0] tim_q,
  output logic             ce_force_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim_q      <= '0;
      ce_force_q <= 1'b0;
    end else if (soft_rst) begin
      tim_q      <= '0;
      ce_force_q <= 1'b0;
    end else begin
      if (tim_wr) tim_q <= tim_wdata;
      if (cfg_wr) ce_force_q <= cfg_ce_force;
    end
  end
endmodule

// File: rtl/nss_phase_fsm.sv
module nss_phase_fsm
  import nss_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     soft_rst,
  input  logic     start,
  input  dir_tim_t tim_in,
  output phase_e   phase,
  output logic     phase_last
);
  logic [WAIT_W-1:0] cnt;
  dir_tim_t          tim_s;

  assign phase_last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      tim_s <= '0;
    end else if (soft_rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_SETUP;
          cnt   <= phase_load(tim_in.setup);
          tim_s <= tim_in;
        end
        PH_SETUP: if (phase_last) begin
          phase <= PH_STROBE;
          cnt   <= phase_load(tim_s.width);
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (phase_last) begin
          phase <= PH_HOLD;
          cnt   <= phase_load(tim_s.hold);
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (phase_last) begin
          if (tim_s.rdy == '0) phase <= PH_IDLE;
          else begin
            phase <= PH_WAIT;
            cnt   <= wait_load(tim_s.rdy);
          end
        end else cnt <= cnt - 1'b1;
        PH_WAIT: if (phase_last) phase <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nss_pin_drive.sv
module nss_pin_drive
  import nss_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              phase_last,
  input  kind_e             kind,
  input  logic [DATA_W-1:0] data,
  input  logic              ce_force,
  input  logic [DATA_W-1:0] nand_din,
  input  logic              nand_rb,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dout,
  output logic              nand_dout_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              dev_ready,
  output logic              rd_capture
);
  logic in_access, is_rd, strobing;

  always_comb begin
    in_access    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    is_rd        = (kind == K_RD);
    strobing     = (phase == PH_STROBE);
    nand_ce_n    = !(ce_force || in_access);
    nand_cle     = in_access && (kind == K_CMD);
    nand_ale     = in_access && (kind == K_ADDR);
    nand_we_n    = !(strobing && !is_rd);
    nand_re_n    = !(strobing && is_rd);
    nand_dout_en = in_access && !is_rd;
    nand_dout    = data;
    rd_capture   = strobing && is_rd && phase_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      dev_ready <= 1'b0;
    end else begin
      rd_valid <= rd_capture;
      if (rd_capture) rd_data <= nand_din;
      if (phase == PH_IDLE) dev_ready <= nand_rb;
    end
  end
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nss_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              tim_wr,
  input  logic [31:0]       tim_wdata,
  input  logic              cfg_wr,
  input  logic              cfg_ce_force,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              dev_ready,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dout,
  output logic              nand_dout_en,
  input  logic [DATA_W-1:0] nand_din,
  input  logic              nand_rb
);
  logic [TIM_W-1:0]  tim_q;
  logic              ce_force_q;
  phase_e            phase;
  logic              phase_last;
  logic              access_start;
  logic              rd_capture;
  kind_e             kind_q;
  logic [DATA_W-1:0] data_q;
  dir_tim_t          tim_sel;

  assign busy         = (phase != PH_IDLE);
  assign access_start = req_valid && !busy && !soft_rst;
  assign tim_sel      = pick_dir(tim_q, kind_e'(req_kind) == K_RD);

  nss_cfg_regs u_cfg (
    .clk, .rst_n, .soft_rst, .tim_wr, .tim_wdata, .cfg_wr, .cfg_ce_force,
    .tim_q, .ce_force_q
  );

  nss_phase_fsm u_fsm (
    .clk, .rst_n, .soft_rst, .start(access_start), .tim_in(tim_sel),
    .phase, .phase_last
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_CMD;
      data_q <= '0;
    end else if (access_start) begin
      kind_q <= kind_e'(req_kind);
      data_q <= req_data;
    end
  end

  nss_pin_drive #(.DATA_W(DATA_W)) u_pins (
    .clk, .rst_n, .phase, .phase_last, .kind(kind_q), .data(data_q),
    .ce_force(ce_force_q), .nand_din, .nand_rb,
    .nand_ce_n, .nand_cle, .nand_ale, .nand_we_n, .nand_re_n,
    .nand_dout, .nand_dout_en, .rd_data, .rd_valid, .dev_ready, .rd_capture
  );
endmodule

// File: rtl/nss_checker.sv
module nss_checker (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic req_valid,
  input logic busy,
  input logic rd_valid,
  input logic dev_ready,
  input logic nand_ce_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_dout_en,
  input logic ce_force_q,
  input logic rd_capture
);
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  p_strobe_in_ce_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
  p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  p_read_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dout_en);
  p_rdv_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_rdv_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> rd_valid);
  p_ready_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(dev_ready));
  p_force_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ce_force_q |-> !nand_ce_n);
  p_soft_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && !ce_force_q));
  p_busy_from_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
endmodule

bind nand_strobe_seq nss_checker chk_i (
  .clk, .rst_n, .soft_rst, .req_valid, .busy, .rd_valid, .dev_ready,
  .nand_ce_n, .nand_cle, .nand_ale, .nand_we_n, .nand_re_n, .nand_dout_en,
  .ce_force_q, .rd_capture
);

// File: tb/nand_strobe_seq_tb_top.sv
module nand_strobe_seq_tb_top;
  logic clk = 0, rst_n = 0, soft_rst = 0, tim_wr = 0, cfg_wr = 0, cfg_ce_force = 0;
  logic [31:0] tim_wdata = 0;
  logic req_valid = 0;
  logic [1:0] req_kind = 0;
  logic [7:0] req_data = 0, nand_din = 0;
  logic nand_rb = 0;
  logic busy, rd_valid, dev_ready, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dout_en;
  logic [7:0] rd_data, nand_dout;

  int n_chk = 0, n_bad = 0;
  int m_setup, m_strobe, m_hold, m_wait, m_busy, m_cle, m_ale, m_we, m_re, m_rdv, m_rdv_pos, m_drvbad, m_stale, m_ce_hi;
  logic [7:0] m_rdata;

  always #5 clk = ~clk;

  nand_strobe_seq dut_i (.*);

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_tim(input logic [31:0] w);
    @(negedge clk); tim_wr = 1; tim_wdata = w;
    @(negedge clk); tim_wr = 0;
  endtask

  task automatic set_force(input logic f);
    @(negedge clk); cfg_wr = 1; cfg_ce_force = f;
    @(negedge clk); cfg_wr = 0;
  endtask

  // Issue one access and measure it at falling edges until busy drops.
  task automatic run_access(input logic [1:0] k, input logic [7:0] d, input int wlen, input bit flip_rb);
    bit seen; int n; logic rdy0;
    m_setup = 0; m_strobe = 0; m_hold = 0; m_wait = 0; m_cle = 0; m_ale = 0; m_we = 0; m_re = 0;
    m_rdv = 0; m_rdv_pos = -1; m_drvbad = 0; m_stale = 0; m_ce_hi = 0; m_rdata = 0;
    seen = 0; n = 0;
    @(negedge clk); req_valid = 1; req_kind = k; req_data = d; nand_din = ~d;
    @(negedge clk); req_valid = 0;
    rdy0 = dev_ready;
    while (busy && n < 400) begin
      if (nand_cle) m_cle++;
      if (nand_ale) m_ale++;
      if (nand_ce_n) m_ce_hi++;
      if (dev_ready != rdy0) m_stale++;
      if (!nand_ce_n || (!nand_we_n || !nand_re_n)) begin
        if (k == 2'b11) begin if (nand_dout_en) m_drvbad++; end
        else if (!seen || !nand_we_n || m_hold >= 0) begin
          if ((!nand_ce_n && !(nand_dout_en && nand_dout == d)) && (m_wait == 0)) m_drvbad++;
        end
      end
      if (rd_valid) begin m_rdv++; m_rdata = rd_data; m_rdv_pos = m_hold + 1; end
      if (!nand_we_n || !nand_re_n) begin
        seen = 1; m_strobe++;
        if (!nand_we_n) m_we++;
        if (!nand_re_n) m_re++;
        nand_din = (m_strobe == wlen + 1) ? d : ~d;
        if (flip_rb) nand_rb = 1;
      end else if (!seen) m_setup++;
      else if (!nand_ce_n && m_wait == 0) m_hold++;
      else m_wait++;
      n++;
      @(negedge clk);
    end
    m_busy = n;
  endtask

  task automatic t_reset_state;
    check("R10 reset busy", busy, 0);
    check("R9 reset ce_n", nand_ce_n, 1);
    check("R11 reset we_n", nand_we_n, 1);
    check("R11 reset re_n", nand_re_n, 1);
    check("R2 reset cle/ale", {nand_cle, nand_ale}, 0);
    check("R5 reset rd_valid", rd_valid, 0);
  endtask

  task automatic t_cmd;
    load_tim(32'h2310_1234);
    run_access(2'b00, 8'h70, 3, 0);
    check("R1 cmd setup", m_setup, 1);
    check("R1 cmd width", m_we, 4);
    check("R1 cmd hold", m_hold, 2);
    check("R6 cmd ready wait", m_wait, 4);
    check("R7 cmd busy", m_busy, 11);
    check("R2 cle cycles", m_cle, 7);
    check("R2 ale cycles", m_ale, 0);
    check("R2 drive byte", m_drvbad, 0);
  endtask

  task automatic t_addr;
    run_access(2'b01, 8'h3C, 3, 0);
    check("R3 ale cycles", m_ale, 7);
    check("R3 cle cycles", m_cle, 0);
    check("R3 we strobe", m_we, 4);
    check("R3 drive byte", m_drvbad, 0);
  endtask

  task automatic t_write;
    load_tim(32'h0F0F_0F0F);
    run_access(2'b10, 8'hA5, 15, 0);
    check("R1 write setup 16", m_setup, 16);
    check("R1 write width 16", m_we, 16);
    check("R1 write hold 1", m_hold, 1);
    check("R6 write no wait", m_wait, 0);
    check("R4 no latch lines", m_cle + m_ale, 0);
    check("R4 drive byte", m_drvbad, 0);
    check("R7 write busy", m_busy, 33);
  endtask

  task automatic t_read;
    load_tim(32'h2310_1234);
    run_access(2'b11, 8'h5A, 2, 0);
    check("R1 read setup", m_setup, 5);
    check("R5 re width", m_re, 3);
    check("R5 no we", m_we, 0);
    check("R1 read hold", m_hold, 4);
    check("R6 read wait", m_wait, 2);
    check("R5 rd_valid count", m_rdv, 1);
    check("R5 rd_data last clock", m_rdata, 8'h5A);
    check("R5 rd_valid first hold", m_rdv_pos, 1);
    check("R5 no drive in read", m_drvbad, 0);
    check("R6 ce high in wait", m_ce_hi, 2);
  endtask

  task automatic t_ready;
    nand_rb = 0;
    repeat (3) @(negedge clk);
    check("R8 idle low", dev_ready, 0);
    run_access(2'b00, 8'hFF, 3, 1);
    check("R8 frozen while busy", m_stale, 0);
    check("R8 first idle still old", dev_ready, 0);
    @(negedge clk);
    check("R8 sampled ready", dev_ready, 1);
    nand_rb = 0;
    @(negedge clk); @(negedge clk);
    check("R8 follows low", dev_ready, 0);
  endtask

  task automatic t_busy_drop;
    int re_seen = 0, after = 0;
    @(negedge clk); req_valid = 1; req_kind = 2'b10; req_data = 8'h11;
    @(negedge clk); req_kind = 2'b11;
    @(negedge clk); @(negedge clk); req_valid = 0;
    while (busy) begin if (!nand_re_n) re_seen++; @(negedge clk); end
    repeat (4) begin if (busy || !nand_re_n) after++; @(negedge clk); end
    check("R7 dropped request strobe", re_seen, 0);
    check("R7 no later access", after, 0);
  endtask

  task automatic t_force;
    set_force(1);
    check("R9 forced idle ce", nand_ce_n, 0);
    run_access(2'b00, 8'h90, 3, 0);
    check("R9 forced through wait", m_ce_hi, 0);
    set_force(0);
    check("R9 released ce", nand_ce_n, 1);
  endtask

  task automatic t_soft;
    set_force(1);
    @(negedge clk); req_valid = 1; req_kind = 2'b10; req_data = 8'h42;
    @(negedge clk); req_valid = 0;
    repeat (2) @(negedge clk);
    check("R10 strobe before reset", nand_we_n, 0);
    soft_rst = 1; @(negedge clk); soft_rst = 0;
    check("R10 idle after", busy, 0);
    check("R10 strobe ended", nand_we_n, 1);
    check("R10 force cleared", nand_ce_n, 1);
    run_access(2'b10, 8'h42, 0, 0);
    check("R10 zero timing busy", m_busy, 3);
    check("R10 zero timing width", m_we, 1);
    check("R10 zero timing setup", m_setup, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_cmd();
    t_addr();
    t_write();
    t_read();
    t_ready();
    load_tim(32'h2310_1234);
    t_busy_drop();
    t_force();
    t_soft();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule